// File: doc/BRIEF.md
# PWM Output Crossover and Gating Unit

This block sits between a three-phase PWM timing unit and the six gate-drive pins of an inverter. It is meant for brushless DC and electronically commutated motor drives. For each phase pair it can swap the high-side and low-side signals, so that one leg's high switch and another leg's low switch can share the same duty cycle. After that swap it can force any of the six pins off one at a time, which lets firmware park a whole leg.

Software writes a 9-bit control word into a shadow register and can read that shadow value back. The word in use (the active copy) changes only at PWM period boundaries: on the rising edge of the period sync, and also at the mid-period strobe when double update mode is selected. As a result, a commutation change never tears a PWM cycle.

Signal index order on both `tu_in` and `pwm_out_o` is: 0 = C low, 1 = C high, 2 = B low, 3 = B high, 4 = A low, 5 = A high. Outputs are active-high.

Top module: `pwm_xover_gate`

## Requirements
- R1: While and after reset, the shadow and active control words are all zero. Readback is 0 and `pwm_out_o` equals `tu_in`.
- R2: When `wr_en_i` is high at a clock edge, `wr_data_i` is stored in the shadow. `rd_data_o` shows the shadow value from the following cycle. The outputs keep using the old active word until a latch event.
- R3: The active word loads the shadow at the clock edge where `sync_i` is sampled high after having been sampled low. The new word affects the outputs from that edge on. Holding `sync_i` high does not cause further loads.
- R4: When `dbl_mode_i` is 1, a clock edge with `mid_i` high also loads the shadow into the active word. When `dbl_mode_i` is 0, `mid_i` has no effect.
- R5: Active bit 8 swaps the A pair (index 5 and index 4), bit 7 swaps the B pair (3 and 2), and bit 6 swaps the C pair (1 and 0). When a pair is swapped, its high pin carries the unit's low-side signal and its low pin carries the unit's high-side signal.
- R6: Active bits 0 to 5 each force the output with the same index to 0. Bit 5 is A high, bit 4 is A low, bit 3 is B high, bit 2 is B low, bit 1 is C high and bit 0 is C low.
- R7: Forcing is applied after swapping, so a disable bit acts on the output pin whatever source the swap routes to it.
- R8: `pwm_out_o` is a combinational function of `tu_in` and the active word, with no clock delay from `tu_in`.
- R9: If a write and a latch event fall on the same edge, the active word takes the shadow value held before that edge. The written value waits for the next latch event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tu_in | input | 6 | Signals from the PWM timing unit |
| sync_i | input | 1 | Period start sync (latch on rising edge) |
| mid_i | input | 1 | Mid-period strobe |
| dbl_mode_i | input | 1 | 1 = double update mode |
| wr_en_i | input | 1 | Shadow write enable |
| wr_data_i | input | 9 | Shadow write data |
| rd_data_o | output | 9 | Shadow readback |
| pwm_out_o | output | 6 | Gate-drive outputs |

## Verification
The output path has zero latency. A change on `tu_in` appears on `pwm_out_o` in the same cycle, so the bench drives on the falling edge and compares shortly afterwards. Control changes pass through exactly one register. A write shows on readback one edge later, and a latch event changes the outputs from the edge where `sync_i` or `mid_i` was sampled. The bench's reference model updates on that same rising edge, and every comparison is made in the low phase that follows, so each expected value is due by then.

// File: rtl/pwm_xg_pkg.sv
package pwm_xg_pkg;
    localparam int NPAIR = 3;
    localparam int NOUT  = 2 * NPAIR;
    localparam int CW    = NOUT + NPAIR;
    localparam int XBASE = NOUT;

    typedef struct packed {
        logic [CW-1:0] shadow;
        logic [CW-1:0] active;
        logic          sync_prev;
    } ctl_state_t;
endpackage

// File: rtl/pwm_xg_ctl.sv
module pwm_xg_ctl
    import pwm_xg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_i,
    input  logic          mid_i,
    input  logic          dbl_mode_i,
    input  logic          wr_en_i,
    input  logic [CW-1:0] wr_data_i,
    output logic [CW-1:0] shadow_o,
    output logic [CW-1:0] active_o
);
    ctl_state_t st_d, st_q;
    logic       latch_now;

    always_comb begin
        st_d      = st_q;
        latch_now = (sync_i && !st_q.sync_prev) || (mid_i && dbl_mode_i);
        if (latch_now) st_d.active = st_q.shadow;
        if (wr_en_i)   st_d.shadow = wr_data_i;
        st_d.sync_prev = sync_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow_o = st_q.shadow;
    assign active_o = st_q.active;
endmodule

// File: rtl/pwm_xg_pair.sv
module pwm_xg_pair (
    input  logic src_hi,
    input  logic src_lo,
    input  logic swap,
    output logic pin_hi,
    output logic pin_lo
);
    always_comb begin
        pin_hi = swap ? src_lo : src_hi;
        pin_lo = swap ? src_hi : src_lo;
    end
endmodule

// File: rtl/pwm_xg_gate.sv
module pwm_xg_gate #(
    parameter int N = 6
) (
    input  logic [N-1:0] sig_i,
    input  logic [N-1:0] kill_i,
    output logic [N-1:0] sig_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign sig_o[i] = sig_i[i] & ~kill_i[i];
    end
endmodule

// File: rtl/pwm_xover_gate.sv
module pwm_xover_gate
    import pwm_xg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NOUT-1:0] tu_in,
    input  logic            sync_i,
    input  logic            mid_i,
    input  logic            dbl_mode_i,
    input  logic            wr_en_i,
    input  logic [CW-1:0]   wr_data_i,
    output logic [CW-1:0]   rd_data_o,
    output logic [NOUT-1:0] pwm_out_o
);
    logic [CW-1:0]   act_word;
    logic [NOUT-1:0] routed;

    pwm_xg_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (sync_i),
        .mid_i      (mid_i),
        .dbl_mode_i (dbl_mode_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .shadow_o   (rd_data_o),
        .active_o   (act_word)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        pwm_xg_pair u_pair (
            .src_hi (tu_in[2*p+1]),
            .src_lo (tu_in[2*p]),
            .swap   (act_word[XBASE+p]),
            .pin_hi (routed[2*p+1]),
            .pin_lo (routed[2*p])
        );
    end

    pwm_xg_gate #(.N(NOUT)) u_gate (
        .sig_i  (routed),
        .kill_i (act_word[NOUT-1:0]),
        .sig_o  (pwm_out_o)
    );
endmodule

// File: rtl/pwm_xover_gate_chk.sv
module pwm_xover_gate_chk
    import pwm_xg_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [NOUT-1:0] tu_in,
    input logic            sync_i,
    input logic            mid_i,
    input logic            dbl_mode_i,
    input logic            wr_en_i,
    input logic [CW-1:0]   wr_data_i,
    input logic [CW-1:0]   rd_data_o,
    input logic [NOUT-1:0] pwm_out_o,
    input logic [CW-1:0]   act_word
);
    logic seen_sync;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_sync <= 1'b0;
        else        seen_sync <= sync_i;
    end

    AST_KILLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_out_o & act_word[NOUT-1:0]) == '0); // R6

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        act_word == '0 |-> pwm_out_o == tu_in); // R8

    AST_SWAP_A: assert property (@(posedge clk) disable iff (!rst_n)
        (act_word[XBASE+2] && !act_word[5]) |-> pwm_out_o[5] == tu_in[4]); // R5

    AST_WRITE_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> rd_data_o == $past(wr_data_i)); // R2

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sync_i && !seen_sync) && !(mid_i && dbl_mode_i)) |=> $stable(act_word)); // R3
endmodule

bind pwm_xover_gate pwm_xover_gate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tu_in      (tu_in),
    .sync_i     (sync_i),
    .mid_i      (mid_i),
    .dbl_mode_i (dbl_mode_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .pwm_out_o  (pwm_out_o),
    .act_word   (act_word)
);

// File: tb/pwm_xover_gate_tb.sv
`timescale 1ns/100ps
module pwm_xover_gate_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] tu_in = '0;
    logic       sync_i = 1'b0, mid_i = 1'b0, dbl_mode_i = 1'b0, wr_en_i = 1'b0;
    logic [8:0] wr_data_i = '0;
    logic [8:0] rd_data_o;
    logic [5:0] pwm_out_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwm_xover_gate u_dut (
        .clk(clk), .rst_n(rst_n), .tu_in(tu_in), .sync_i(sync_i), .mid_i(mid_i),
        .dbl_mode_i(dbl_mode_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .pwm_out_o(pwm_out_o)
    );

    // Reference state built from the requirements
    logic [8:0] m_sh, m_act;
    logic       m_sp;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sh <= '0; m_act <= '0; m_sp <= 1'b0;
        end else begin
            if ((sync_i && !m_sp) || (mid_i && dbl_mode_i)) m_act <= m_sh; // R3 R4 R9
            if (wr_en_i) m_sh <= wr_data_i;                                // R2
            m_sp <= sync_i;
        end
    end

    function automatic logic [5:0] exp_out(logic [5:0] tu, logic [8:0] w);
        logic [5:0] r;
        for (int p = 0; p < 3; p++) begin
            r[2*p+1] = w[6+p] ? tu[2*p]   : tu[2*p+1]; // R5
            r[2*p]   = w[6+p] ? tu[2*p+1] : tu[2*p];
        end
        return r & ~w[5:0];                            // R6 R7
    endfunction

    task automatic chk(string tag, logic [8:0] got, logic [8:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(string tag, logic [5:0] tu, logic s, logic m, logic d,
                        logic we, logic [8:0] wd);
        @(negedge clk);
        tu_in = tu; sync_i = s; mid_i = m; dbl_mode_i = d; wr_en_i = we; wr_data_i = wd;
        #1;
        chk({tag, " out"}, {3'b0, pwm_out_o}, {3'b0, exp_out(tu, m_act)});
        chk({tag, " rd"}, rd_data_o, m_sh);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int per;
        void'($urandom(32'h5EED));
        tu_in = 6'b101101;
        #9;
        // R1: reset state
        chk("R1 rd in reset", rd_data_o, 9'h000);
        chk("R1 out in reset", {3'b0, pwm_out_o}, {3'b0, 6'b101101});
        @(negedge clk); rst_n = 1'b1;
        step("R1", 6'b010110, 0, 0, 0, 0, 0);
        // R2: write reaches shadow only
        step("R2", 6'b111111, 0, 0, 0, 1, 9'h1FF);
        step("R2", 6'b111111, 0, 0, 0, 0, 0);
        chk("R2 still passing", {3'b0, pwm_out_o}, {3'b0, 6'b111111});
        // R3: rising sync latches, held sync does not
        step("R3", 6'b111111, 1, 0, 0, 0, 0);
        step("R3", 6'b111111, 1, 0, 0, 1, 9'h000);
        chk("R3 latched all off", {3'b0, pwm_out_o}, 9'h000);
        step("R3 held", 6'b111111, 1, 0, 0, 0, 0);
        step("R3 held", 6'b111111, 1, 0, 0, 0, 0);
        chk("R3 no relatch", {3'b0, pwm_out_o}, 9'h000);
        step("R3", 6'b111111, 0, 0, 0, 0, 0);
        step("R3", 6'b111111, 1, 0, 0, 0, 0);
        step("R3", 6'b101010, 0, 0, 0, 0, 0);
        chk("R3 relatch zero", {3'b0, pwm_out_o}, {3'b0, 6'b101010});
        // R4: midpoint ignored in single mode, used in double mode
        step("R4", 6'b111111, 0, 0, 0, 1, 9'h03F);
        step("R4 single", 6'b111111, 0, 1, 0, 0, 0);
        step("R4 single", 6'b111111, 0, 0, 0, 0, 0);
        chk("R4 mid ignored", {3'b0, pwm_out_o}, {3'b0, 6'b111111});
        step("R4 double", 6'b111111, 0, 1, 1, 0, 0);
        step("R4 double", 6'b111111, 0, 0, 1, 0, 0);
        chk("R4 mid latched", {3'b0, pwm_out_o}, 9'h000);
        // R9: write on the latch edge
        step("R9", 6'b111111, 1, 0, 0, 1, 9'h000);
        step("R9", 6'b111111, 0, 0, 0, 0, 0);
        chk("R9 old shadow used", {3'b0, pwm_out_o}, 9'h000);
        step("R9", 6'b111111, 1, 0, 0, 0, 0);
        step("R9", 6'b111111, 0, 0, 0, 0, 0);
        chk("R9 new value later", {3'b0, pwm_out_o}, {3'b0, 6'b111111});
        // R5 R7: swap B, kill B high pin
        step("R7", 6'b000000, 0, 0, 0, 1, 9'h088);
        step("R7", 6'b000000, 1, 0, 0, 0, 0);
        step("R7", 6'b001000, 0, 0, 0, 0, 0);
        chk("R5 B high to low pin", {3'b0, pwm_out_o}, {3'b0, 6'b000100});
        step("R7", 6'b000100, 0, 0, 0, 0, 0);
        chk("R7 pin killed after swap", {3'b0, pwm_out_o}, 9'h000);
        // R8 R5 R6: random traffic with periodic sync and mid strobes
        for (int k = 0; k < 4000; k++) begin
            per = 16;
            step("R5 R6 R7 R8 random", 6'($urandom), (k % per) < 3,
                 (k % per) == 8, (k / 500) % 2 == 1,
                 ($urandom % 7) == 0, 9'($urandom));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule